// File: doc/BRIEF.md
# Floating-Point Subtract with Parallel Load Unit

This unit executes one instruction form of a small floating-point coprocessor. The instruction does two things in the same clock edge. It subtracts one entry of a four-entry single-precision register file from another and writes the difference back. It also copies a 32-bit word from the memory read-data port into a different register. Address generation and the memory itself are outside the unit. The unit sees only the instruction word, a valid strobe and the data word that the memory returns for that instruction.

The subtraction uses single-precision format with round-to-nearest-even. Subnormal operands and subnormal results are flushed to signed zero, and results that are too large saturate to the largest finite magnitude. Five status flags are held: test, zero, negative, latched underflow and latched overflow. The zero and negative flags describe the loaded word, not the difference. The two latched flags record arithmetic exceptions until a clear strobe or reset removes them. When an instruction names the same register for both writes, it is refused and an illegal-instruction output is raised.

Top module: `fsub_load_unit`

## Requirements
- R1: While reset is asserted and after it is released, all four registers read zero, all five status bits are zero and `illegal` is low.
- R2: An instruction is accepted only when `instrValid` is high and `instrWord[31:28]` equals 4'b0010. Any other word, or a word presented while `instrValid` is low, changes no register and no flag.
- R3: An accepted instruction writes register `instrWord[23:22]` with register `instrWord[25:24]` minus register `instrWord[27:26]`. Bits 19:0 of the word have no effect.
- R4: On the same rising edge, an accepted instruction writes register `instrWord[21:20]` with `memRdata` unchanged.
- R5: When `instrWord[23:22]` equals `instrWord[21:20]` on a valid word with the right opcode, `illegal` is high in that same cycle. No register is written, and the zero, negative and latched flags keep their values. `illegal` is low at all other times.
- R6: On an accepted instruction, negative takes `memRdata[31]` and zero is cleared. If `memRdata[30:23]` is all zeros, zero is set instead and negative is forced to 0.
- R7: Latched underflow and latched overflow are set by an underflowing or overflowing subtraction and are never cleared by an instruction. A high `flagClr` clears both at the next edge, but a new exception in the same cycle wins over the clear. The test flag always reads 0.
- R8: The difference is rounded to nearest, with ties going to an even significand.
- R9: Operands whose exponent field is zero count as zero with their sign. A nonzero result below the smallest normal magnitude becomes zero with its sign kept and sets latched underflow. An exact zero difference is +0 and is not an underflow.
- R10: A result whose exponent reaches 255, before or after rounding, becomes the largest finite magnitude 0x7F7FFFFF with the result sign and sets latched overflow. Exponent field 255 in an operand is treated as an ordinary exponent.
- R11: `rdData` shows register `rdSel` combinationally. `statusOut` is {test, zero, negative, latched underflow, latched overflow}, with bit 4 the test flag and bit 0 latched overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | Instruction word is present this cycle |
| instrWord | input | 32 | Instruction word |
| memRdata | input | 32 | Data word returned for the load half |
| flagClr | input | 1 | Clears both latched exception flags |
| rdSel | input | 2 | Register readback select |
| illegal | output | 1 | Same destination for both writes |
| rdData | output | 32 | Contents of register rdSel |
| statusOut | output | 5 | {test, zero, negative, underflow, overflow} |

## Verification
Register and flag results are written on the first rising edge after a valid word is presented. They therefore become visible one edge after the stimulus. `illegal` is a combinational function of the word on the inputs and is due in the same cycle, before any edge. The bench drives each word on a falling edge and samples `illegal` one nanosecond later. It then waits through exactly one rising edge and reads registers and flags after the next falling edge, stepping `rdSel` with a short settling delay because readback has no register stage. Operand values are first placed through the load path, so every arithmetic check also depends on load timing being exactly one edge.

// File: rtl/fsub_load_pkg.sv
package fsub_load_pkg;

  localparam int REG_CNT = 4;
  localparam int SEL_W   = $clog2(REG_CNT);
  localparam int WORD_W  = 32;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int GRS_W   = 3;
  localparam int ALN_W   = MANT_W + GRS_W;
  localparam int LZ_W    = $clog2(ALN_W + 1);
  localparam int EXPS_W  = EXP_W + 2;
  localparam int STAT_W  = 5;

  // instruction field positions (the field decode depends on them)
  localparam int OPC_LSB = 28;
  localparam int SUB_LSB = 26;
  localparam int MIN_LSB = 24;
  localparam int DIF_LSB = 22;
  localparam int LD_LSB  = 20;

  localparam logic [3:0]          OPC_FSUBLD = 4'b0010;
  localparam logic [EXP_W-1:0]    EXP_TOP    = '1;
  localparam logic [WORD_W-2:0]   MAX_MAG    = {EXP_TOP - 8'd1, {FRAC_W{1'b1}}};

  typedef struct packed {
    logic             wrEn;
    logic [SEL_W-1:0] minSel;
    logic [SEL_W-1:0] subSel;
    logic [SEL_W-1:0] difDst;
    logic [SEL_W-1:0] ldDst;
  } ctlStrobe_t;

  typedef struct packed {
    logic tf;
    logic zf;
    logic nf;
    logic luf;
    logic lvf;
  } status_t;

endpackage

// File: rtl/fsub_load_ctrl.sv
module fsub_load_ctrl
  import fsub_load_pkg::*;
(
  input  logic              instrValid,
  input  logic [WORD_W-1:0] instrWord,
  output ctlStrobe_t        ctl,
  output logic              illegal
);

  logic opcodeHit;
  logic dstClash;
  logic unusedAddr;

  assign opcodeHit = instrValid && (instrWord[OPC_LSB +: 4] == OPC_FSUBLD);
  assign dstClash  = instrWord[DIF_LSB +: SEL_W] == instrWord[LD_LSB +: SEL_W];

  // addressing bits and memory operand field belong to address generation
  assign unusedAddr = ^instrWord[LD_LSB-1:0];

  always_comb begin
    ctl.minSel = instrWord[MIN_LSB +: SEL_W];
    ctl.subSel = instrWord[SUB_LSB +: SEL_W];
    ctl.difDst = instrWord[DIF_LSB +: SEL_W];
    ctl.ldDst  = instrWord[LD_LSB  +: SEL_W];
    ctl.wrEn   = opcodeHit && !dstClash;
  end

  assign illegal = opcodeHit && dstClash;

endmodule

// File: rtl/fsub_core.sv
module fsub_core
  import fsub_load_pkg::*;
(
  input  logic [WORD_W-1:0] minuend,
  input  logic [WORD_W-1:0] subtrahend,
  output logic [WORD_W-1:0] diff,
  output logic              underflow,
  output logic              overflow
);

  function automatic logic [LZ_W-1:0] leadZeros(input logic [ALN_W-1:0] v);
    logic [LZ_W-1:0] n;
    n = LZ_W'(ALN_W);
    for (int i = 0; i < ALN_W; i++) begin
      if (v[i]) n = LZ_W'(ALN_W - 1 - i);
    end
    return n;
  endfunction

  logic                     sgnA, sgnB, sgnBig, sgnSml;
  logic [EXP_W-1:0]         expA, expB, expBig, expSml, shAmt;
  logic [MANT_W-1:0]        manA, manB, manBig, manSml;
  logic                     aWins, effSub;
  logic [ALN_W-1:0]         bigExt, smlExt, lostMask, aligned;
  logic [ALN_W:0]           sumRaw;
  logic [LZ_W-1:0]          lz;
  logic [ALN_W-1:0]         normMan;
  logic signed [EXPS_W-1:0] normExp, finExp;
  logic [MANT_W-1:0]        keep;
  logic                     guardB, stickyB, rndUp;
  logic [MANT_W:0]          rnd;
  logic [FRAC_W-1:0]        finFrac;
  logic                     unusedHidden;

  // operand unpack, subnormals read as signed zero, subtrahend sign flipped
  always_comb begin
    sgnA = minuend[WORD_W-1];
    sgnB = ~subtrahend[WORD_W-1];
    expA = minuend[FRAC_W +: EXP_W];
    expB = subtrahend[FRAC_W +: EXP_W];
    manA = (expA == '0) ? '0 : {1'b1, minuend[FRAC_W-1:0]};
    manB = (expB == '0) ? '0 : {1'b1, subtrahend[FRAC_W-1:0]};
    aWins = {expA, manA} >= {expB, manB};
    if (aWins) begin
      sgnBig = sgnA; expBig = expA; manBig = manA;
      sgnSml = sgnB; expSml = expB; manSml = manB;
    end else begin
      sgnBig = sgnB; expBig = expB; manBig = manB;
      sgnSml = sgnA; expSml = expA; manSml = manA;
    end
  end

  // alignment with guard, round and sticky bits
  always_comb begin
    shAmt    = expBig - expSml;
    bigExt   = {manBig, {GRS_W{1'b0}}};
    smlExt   = {manSml, {GRS_W{1'b0}}};
    lostMask = '0;
    if (shAmt >= EXP_W'(ALN_W)) begin
      aligned = {{(ALN_W-1){1'b0}}, |smlExt};
    end else begin
      lostMask = (ALN_W'(1) << shAmt) - ALN_W'(1);
      aligned  = (smlExt >> shAmt) | {{(ALN_W-1){1'b0}}, |(smlExt & lostMask)};
    end
    effSub = sgnBig ^ sgnSml;
    sumRaw = effSub ? ({1'b0, bigExt} - {1'b0, aligned})
                    : ({1'b0, bigExt} + {1'b0, aligned});
  end

  // normalization
  always_comb begin
    lz = '0;
    if (sumRaw[ALN_W]) begin
      normMan = sumRaw[ALN_W:1] | {{(ALN_W-1){1'b0}}, sumRaw[0]};
      normExp = $signed(EXPS_W'(expBig)) + EXPS_W'(1);
    end else begin
      lz      = leadZeros(sumRaw[ALN_W-1:0]);
      normMan = sumRaw[ALN_W-1:0] << lz;
      normExp = $signed(EXPS_W'(expBig)) - $signed(EXPS_W'(lz));
    end
  end

  // round to nearest, ties to even
  always_comb begin
    keep    = normMan[ALN_W-1:GRS_W];
    guardB  = normMan[GRS_W-1];
    stickyB = |normMan[GRS_W-2:0];
    rndUp   = guardB && (stickyB || keep[0]);
    rnd     = {1'b0, keep} + (MANT_W+1)'(rndUp);
    if (rnd[MANT_W]) begin
      finExp  = normExp + EXPS_W'(1);
      finFrac = '0;
    end else begin
      finExp  = normExp;
      finFrac = rnd[FRAC_W-1:0];
    end
  end

  assign unusedHidden = rnd[FRAC_W];

  // pack with saturation and flush to zero
  always_comb begin
    underflow = 1'b0;
    overflow  = 1'b0;
    if (sumRaw == '0) begin
      diff = {effSub ? 1'b0 : sgnBig, {(WORD_W-1){1'b0}}};
    end else if (finExp >= $signed(EXPS_W'(EXP_TOP))) begin
      diff     = {sgnBig, MAX_MAG};
      overflow = 1'b1;
    end else if (finExp <= $signed(EXPS_W'(0))) begin
      diff      = {sgnBig, {(WORD_W-1){1'b0}}};
      underflow = 1'b1;
    end else begin
      diff = {sgnBig, finExp[EXP_W-1:0], finFrac};
    end
    AST_EXC_EXCLUSIVE: assert (!(underflow && overflow)); // R9
  end

endmodule

// File: rtl/fsub_load_dp.sv
module fsub_load_dp
  import fsub_load_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              flagClr,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [WORD_W-1:0] rdData,
  output logic [STAT_W-1:0] statusOut
);

  logic [REG_CNT-1:0][WORD_W-1:0] regQ;
  status_t                        stat;
  logic [WORD_W-1:0]              subDiff;
  logic                           subUnf;
  logic                           subOvf;
  logic                           ldExpZero;

  fsub_core u_core (
    .minuend    (regQ[ctl.minSel]),
    .subtrahend (regQ[ctl.subSel]),
    .diff       (subDiff),
    .underflow  (subUnf),
    .overflow   (subOvf)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= '0;
    end else begin
      for (int i = 0; i < REG_CNT; i++) begin
        if (ctl.wrEn && ctl.difDst == SEL_W'(i)) regQ[i] <= subDiff;
        else if (ctl.wrEn && ctl.ldDst == SEL_W'(i)) regQ[i] <= memRdata;
      end
    end
  end

  assign ldExpZero = memRdata[FRAC_W +: EXP_W] == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stat <= '0;
    end else begin
      if (ctl.wrEn) begin
        stat.zf <= ldExpZero;
        stat.nf <= memRdata[WORD_W-1] && !ldExpZero;
      end
      stat.luf <= (stat.luf && !flagClr) || (ctl.wrEn && subUnf);
      stat.lvf <= (stat.lvf && !flagClr) || (ctl.wrEn && subOvf);
    end
  end

  assign rdData    = regQ[rdSel];
  assign statusOut = stat;

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |=> regQ[$past(ctl.ldDst)] == $past(memRdata)); // R4
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.wrEn |=> $stable(regQ)); // R5
  AST_LUF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (stat.luf && !flagClr) |=> stat.luf); // R7
  AST_LVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (stat.lvf && !flagClr) |=> stat.lvf); // R7
  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rstN)
    stat.zf |-> !stat.nf); // R6
  AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEn && subOvf) |=> regQ[$past(ctl.difDst)][WORD_W-2:0] == MAX_MAG); // R10
  AST_UNF_FLUSHES: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEn && subUnf) |=> regQ[$past(ctl.difDst)][WORD_W-2:0] == '0); // R9

endmodule

// File: rtl/fsub_load_unit.sv
module fsub_load_unit
  import fsub_load_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [WORD_W-1:0] instrWord,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              flagClr,
  input  logic [SEL_W-1:0]  rdSel,
  output logic              illegal,
  output logic [WORD_W-1:0] rdData,
  output logic [STAT_W-1:0] statusOut
);

  ctlStrobe_t ctl;

  fsub_load_ctrl u_ctrl (
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .ctl        (ctl),
    .illegal    (illegal)
  );

  fsub_load_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .memRdata  (memRdata),
    .flagClr   (flagClr),
    .rdSel     (rdSel),
    .rdData    (rdData),
    .statusOut (statusOut)
  );

  AST_ILLEGAL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> instrValid); // R5

endmodule

// File: tb/fsub_load_unit_tb.sv
module fsub_load_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] memRdata = '0;
  logic        flagClr = 1'b0;
  logic [1:0]  rdSel = '0;
  logic        illegal;
  logic [31:0] rdData;
  logic [4:0]  statusOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fsub_load_unit u_dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .memRdata(memRdata), .flagClr(flagClr), .rdSel(rdSel),
    .illegal(illegal), .rdData(rdData), .statusOut(statusOut)
  );

  localparam logic [31:0] PRE_R0 = 32'h2FC0_0000; // R3=R3-R3, load R0
  localparam logic [31:0] PRE_R1 = 32'h2FD0_0000; // R3=R3-R3, load R1
  localparam logic [31:0] MAIN   = 32'h24B0_0000; // R2=R0-R1, load R3
  localparam logic [31:0] CLASH  = 32'h24A0_0000; // both destinations R2
  localparam logic [31:0] BADOPC = 32'h34B0_0000;

  localparam int NVEC = 12;
  // {minuend, subtrahend, mem word, expected diff, expected status}
  localparam logic [132:0] VECS [NVEC] = '{
    {32'h4040_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h4000_0000, 5'b00000},
    {32'h3F80_0000, 32'h4040_0000, 32'hBF80_0000, 32'hC000_0000, 5'b00100},
    {32'h3FC0_0000, 32'h3FC0_0000, 32'h0000_0000, 32'h0000_0000, 5'b01000},
    {32'h4020_0000, 32'hBFA0_0000, 32'h8000_0000, 32'h4070_0000, 5'b01000},
    {32'h7F7F_FFFF, 32'hFF7F_FFFF, 32'h807F_FFFF, 32'h7F7F_FFFF, 5'b01001},
    {32'h00C0_0000, 32'h0080_0000, 32'h1234_5678, 32'h0000_0000, 5'b00010},
    {32'h80C0_0000, 32'h8080_0000, 32'hC120_0000, 32'h8000_0000, 5'b00110},
    {32'h3F80_0000, 32'h3300_0000, 32'h0080_0000, 32'h3F80_0000, 5'b00000},
    {32'h3F80_0000, 32'hB380_0000, 32'h8080_0000, 32'h3F80_0000, 5'b00100},
    {32'h3F80_0000, 32'hB440_0000, 32'h7F80_0000, 32'h3F80_0002, 5'b00000},
    {32'h7F7F_FFFF, 32'hF300_0000, 32'hFF80_0000, 32'h7F7F_FFFF, 5'b00101},
    {32'h0040_0000, 32'h3F80_0000, 32'h0000_0001, 32'hBF80_0000, 5'b01000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [31:0] v);
    rdSel = sel;
    #1;
    v = rdData;
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] m, input logic vld,
                       input logic clr, output logic ill);
    @(negedge clk);
    instrWord = w; memRdata = m; instrValid = vld; flagClr = clr;
    #1 ill = illegal;
    @(negedge clk);
    instrValid = 1'b0; flagClr = 1'b0;
  endtask

  task automatic clearFlags();
    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  task automatic chkStat(input string tag, input logic [4:0] exp);
    chk(tag, {27'b0, statusOut}, {27'b0, exp});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic        ill;

    // R1 reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int r = 0; r < 4; r++) begin
      readReg(2'(r), v);
      chk($sformatf("R1 reg%0d after reset", r), v, 32'h0);
    end
    chkStat("R1 status after reset", 5'b00000);
    chk("R1 illegal after reset", {31'b0, illegal}, 32'h0);

    // table walk: R3 R4 R6 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      issue(PRE_R0, VECS[i][132:101], 1'b1, 1'b0, ill);
      issue(PRE_R1, VECS[i][100:69], 1'b1, 1'b0, ill);
      clearFlags();
      issue(MAIN, VECS[i][68:37], 1'b1, 1'b0, ill);
      chk($sformatf("R5 vec%0d legal word not flagged", i), {31'b0, ill}, 32'h0);
      readReg(2'd2, v);
      chk($sformatf("R3 R8 R9 R10 vec%0d difference", i), v, VECS[i][36:5]);
      readReg(2'd3, v);
      chk($sformatf("R4 vec%0d loaded word", i), v, VECS[i][68:37]);
      chkStat($sformatf("R6 R7 vec%0d status", i), VECS[i][4:0]);
    end

    // R5 clashing destinations: flagged, nothing written
    issue(CLASH, 32'hDEAD_BEEF, 1'b1, 1'b0, ill);
    chk("R5 illegal raised", {31'b0, ill}, 32'h1);
    readReg(2'd2, v);
    chk("R5 R2 kept", v, 32'hBF80_0000);
    readReg(2'd3, v);
    chk("R5 R3 kept", v, 32'h0000_0001);
    chkStat("R5 status kept", 5'b01000);

    // R2 wrong opcode and missing valid
    issue(BADOPC, 32'hDEAD_BEEF, 1'b1, 1'b0, ill);
    chk("R2 wrong opcode not flagged", {31'b0, ill}, 32'h0);
    readReg(2'd2, v);
    chk("R2 wrong opcode R2 kept", v, 32'hBF80_0000);
    chkStat("R2 wrong opcode status kept", 5'b01000);
    issue(MAIN, 32'hDEAD_BEEF, 1'b0, 1'b0, ill);
    readReg(2'd3, v);
    chk("R2 no valid R3 kept", v, 32'h0000_0001);
    readReg(2'd2, v);
    chk("R2 no valid R2 kept", v, 32'hBF80_0000);

    // R11 combinational readback
    readReg(2'd0, v);
    chk("R11 readback R0", v, 32'h0040_0000);
    readReg(2'd1, v);
    chk("R11 readback R1", v, 32'h3F80_0000);

    // R7 latching, clear, and set winning over clear
    issue(PRE_R0, 32'h7F7F_FFFF, 1'b1, 1'b0, ill);
    issue(PRE_R1, 32'hFF7F_FFFF, 1'b1, 1'b0, ill);
    clearFlags();
    issue(MAIN, 32'h4000_0000, 1'b1, 1'b0, ill);
    chkStat("R7 overflow latched", 5'b00001);
    issue(PRE_R0, 32'h3F80_0000, 1'b1, 1'b0, ill);
    chkStat("R7 overflow survives clean op", 5'b00001);
    clearFlags();
    chkStat("R7 clear removes latch", 5'b00000);
    issue(PRE_R0, 32'h7F7F_FFFF, 1'b1, 1'b0, ill);
    issue(MAIN, 32'h4000_0000, 1'b1, 1'b1, ill);
    chkStat("R7 set wins over clear", 5'b00001);

    // R3 R4 other field combination, low 20 bits nonzero
    clearFlags();
    issue(PRE_R0, 32'h40A0_0000, 1'b1, 1'b0, ill);
    issue(32'h2070_0000, 32'h4100_0000, 1'b1, 1'b0, ill);
    issue(32'h2367_ABCD, 32'hC080_0000, 1'b1, 1'b0, ill);
    readReg(2'd1, v);
    chk("R3 R1 = R3 - R0", v, 32'h4040_0000);
    readReg(2'd2, v);
    chk("R4 R2 loaded", v, 32'hC080_0000);
    readReg(2'd0, v);
    chk("R3 R0 untouched", v, 32'h40A0_0000);
    readReg(2'd3, v);
    chk("R4 R3 untouched", v, 32'h4100_0000);
    chkStat("R6 negative from load", 5'b00100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule